// File: doc/BRIEF.md
# Endpoint Buffer State Controller

This block keeps the buffer bookkeeping for one endpoint of a device-side USB controller. On the transmit side it counts the bytes firmware pushes into the transmit FIFO. The buffer is armed for sending when that count reaches the programmed maximum packet size. Firmware can also arm it early with a validate command, which sends a short packet or, if the buffer is empty, a zero-length packet. An acknowledged IN transaction disarms the buffer, zeroes the count and flips the data toggle.

On the receive side the block tracks one buffer, or two buffers used in ping-pong order. A buffer fills from the bus side and is marked full at the end of a packet. It stays full until firmware has read every byte, or until a clear command empties it. Each clear command empties exactly one buffer, always the oldest full one, and never touches the transmit side.

The data toggle only returns to DATA0 when the endpoint is disabled. A stall blocks sending but leaves the toggle where it was. Memory arrays and line signalling are outside this block: it sees only strobes and produces flags and counts.

Top module: `ep_buf_ctrl`

## Requirements
- R1: A transmit byte write accepted while the buffer is not armed adds one to `tx_count`. When the new count reaches or passes `max_pkt`, `tx_ready` is 1 on the next cycle.
- R2: A `tx_validate` strobe while not armed sets `tx_ready` on the next cycle and keeps `tx_count`. With an empty buffer this arms a zero-length packet (`tx_count` 0).
- R3: `in_ack` while armed, enabled and not stalled clears `tx_ready` and `tx_count` to 0 and inverts `data_toggle` on the next cycle. In any other state `in_ack` changes none of these outputs.
- R4: Transmit byte writes while `tx_ready` is 1 are ignored; `tx_count` stays unchanged.
- R5: `rx_wr` adds a byte to the buffer currently being filled, up to `max_pkt` bytes; writes beyond that are dropped. `rx_pkt_end` marks that buffer full. Writes and packet ends aimed at a full buffer are ignored.
- R6: `rx_rd` on the oldest full buffer lowers `rx_count` by one. Reading its last byte empties it. A full buffer stays full with a stable count while it is neither read nor cleared.
- R7: A rising edge of `rx_clear` empties the oldest full buffer (count 0). Holding the bit high clears no further buffers. The transmit outputs are not affected.
- R8: With `DOUBLE_BUF`=1, packets fill the two buffers alternately and are presented oldest first. When both are full, one clear leaves exactly one full, so two set/clear cycles are needed to empty both. `rx_full` has one bit per buffer and `rx_avail` shows that the oldest buffer is full.
- R9: `ep_enable` low resets `data_toggle` to 0 on the next cycle. `tx_stall` blocks `in_ack` and leaves the toggle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_enable | input | 1 | Endpoint enabled; low resets the data toggle |
| tx_stall | input | 1 | Endpoint stalled; blocks sending |
| max_pkt | input | CNT_W | Maximum packet size in bytes |
| tx_wr | input | 1 | Firmware byte write into the transmit FIFO |
| tx_validate | input | 1 | Force-arm strobe for a short packet |
| in_ack | input | 1 | IN packet sent and acknowledged |
| rx_wr | input | 1 | Bus byte written into the receive buffer |
| rx_pkt_end | input | 1 | End of received packet |
| rx_rd | input | 1 | Firmware byte read from the receive buffer |
| rx_clear | input | 1 | Clear command bit; acts on its rising edge |
| tx_ready | output | 1 | Transmit buffer armed |
| tx_count | output | CNT_W | Bytes in the transmit buffer |
| data_toggle | output | 1 | Current data toggle (0 = DATA0) |
| rx_full | output | DOUBLE_BUF+1 | Full flag per receive buffer |
| rx_avail | output | 1 | Oldest receive buffer is full |
| rx_count | output | CNT_W | Bytes left in the oldest receive buffer |

## Verification
The bench sweeps the packet size for the auto-arm boundary. A design off by one would arm a byte early or late, or keep counting writes after arming. It sweeps every short length, including zero, under validate, and checks that send, stall and disable each leave the toggle as expected. On the receive side it fills both ping-pong buffers over a grid of packet lengths and pushes a third packet against them. A design that overwrote a full buffer, served the newer one first or cleared both with one held clear bit would show wrong counts or flags.

// File: rtl/ep_buf_pkg.sv
package ep_buf_pkg;
  localparam int EP_CNT_W = 11;

  typedef enum logic {
    TX_FILL  = 1'b0,
    TX_ARMED = 1'b1
  } tx_state_e;
endpackage

// File: rtl/ep_tx_ctrl.sv
module ep_tx_ctrl
  import ep_buf_pkg::*;
#(
  parameter int CNT_W = EP_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ep_enable,
  input  logic             tx_stall,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             tx_wr,
  input  logic             tx_validate,
  input  logic             in_ack,
  output logic             tx_ready,
  output logic [CNT_W-1:0] tx_count,
  output logic             data_toggle
);
  tx_state_e        state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_inc;
  logic             tog_q, tog_n;
  logic             send;

  assign cnt_inc = cnt_q + 1'b1;
  assign send    = (state_q == TX_ARMED) && in_ack && ep_enable && !tx_stall;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    tog_n   = tog_q;
    if (send) begin
      state_n = TX_FILL;
      cnt_n   = '0;
      tog_n   = ~tog_q;
    end else if (state_q == TX_FILL) begin
      if (tx_wr) begin
        cnt_n = cnt_inc;
        if (cnt_inc >= max_pkt) state_n = TX_ARMED;
      end
      if (tx_validate) state_n = TX_ARMED;
    end
    if (!ep_enable) tog_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_FILL;
      cnt_q   <= '0;
      tog_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      tog_q   <= tog_n;
    end
  end

  assign tx_ready    = (state_q == TX_ARMED);
  assign tx_count    = cnt_q;
  assign data_toggle = tog_q;

  assert_auto_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && tx_wr && ((tx_count + 1'b1) >= max_pkt)) |=> tx_ready);
  assert_validate_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && tx_validate && !tx_wr) |=> (tx_ready && $stable(tx_count)));
  assert_send_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && in_ack && ep_enable && !tx_stall) |=> (!tx_ready && tx_count == '0));
  assert_armed_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !(in_ack && ep_enable && !tx_stall)) |=> (tx_ready && $stable(tx_count)));
  assert_toggle_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_enable |=> !data_toggle);
endmodule

// File: rtl/ep_rx_bank.sv
module ep_rx_bank
  import ep_buf_pkg::*;
#(
  parameter int CNT_W = EP_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             wr,
  input  logic             pkt_end,
  input  logic             rd,
  input  logic             clr,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic             full_q, full_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             wr_ok, end_ok, rd_ok, clr_ok;

  assign wr_ok  = !full_q && wr && (cnt_q < max_pkt);
  assign end_ok = !full_q && pkt_end;
  assign rd_ok  = full_q && rd && (cnt_q != '0);
  assign clr_ok = full_q && clr;

  always_comb begin
    full_n = full_q;
    cnt_n  = cnt_q;
    if (clr_ok) begin
      full_n = 1'b0;
      cnt_n  = '0;
    end else if (rd_ok) begin
      cnt_n  = cnt_q - 1'b1;
      full_n = (cnt_q != CNT_W'(1));
    end else begin
      if (wr_ok)  cnt_n  = cnt_q + 1'b1;
      if (end_ok) full_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      full_q <= full_n;
      cnt_q  <= cnt_n;
    end
  end

  assign full  = full_q;
  assign count = cnt_q;

  assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd && !clr) |=> (full && $stable(count)));
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && clr) |=> (!full && count == '0));
  assert_no_overfill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && count >= max_pkt && !pkt_end && $stable(max_pkt)) |=> $stable(count));
endmodule

// File: rtl/ep_buf_ctrl.sv
module ep_buf_ctrl
  import ep_buf_pkg::*;
#(
  parameter int CNT_W      = EP_CNT_W,
  parameter int DOUBLE_BUF = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ep_enable,
  input  logic              tx_stall,
  input  logic [CNT_W-1:0]  max_pkt,
  input  logic              tx_wr,
  input  logic              tx_validate,
  input  logic              in_ack,
  input  logic              rx_wr,
  input  logic              rx_pkt_end,
  input  logic              rx_rd,
  input  logic              rx_clear,
  output logic              tx_ready,
  output logic [CNT_W-1:0]  tx_count,
  output logic              data_toggle,
  output logic [DOUBLE_BUF:0] rx_full,
  output logic              rx_avail,
  output logic [CNT_W-1:0]  rx_count
);
  localparam int NBUF = DOUBLE_BUF + 1;

  logic clr_q;
  logic clr_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= rx_clear;
  end
  assign clr_pulse = rx_clear && !clr_q;

  ep_tx_ctrl #(.CNT_W(CNT_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .ep_enable   (ep_enable),
    .tx_stall    (tx_stall),
    .max_pkt     (max_pkt),
    .tx_wr       (tx_wr),
    .tx_validate (tx_validate),
    .in_ack      (in_ack),
    .tx_ready    (tx_ready),
    .tx_count    (tx_count),
    .data_toggle (data_toggle)
  );

  logic [CNT_W-1:0] bank_cnt [NBUF];
  logic [NBUF-1:0]  bank_full;

  generate
    if (DOUBLE_BUF != 0) begin : g_pingpong
      logic wr_sel_q, wr_sel_n, rd_sel_q, rd_sel_n;
      logic rd_leaves;

      assign rd_leaves = bank_full[rd_sel_q] &&
                         (clr_pulse || (rx_rd && bank_cnt[rd_sel_q] == CNT_W'(1)));

      always_comb begin
        wr_sel_n = wr_sel_q;
        rd_sel_n = rd_sel_q;
        if (rx_pkt_end && !bank_full[wr_sel_q]) wr_sel_n = ~wr_sel_q;
        if (rd_leaves) rd_sel_n = ~rd_sel_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wr_sel_q <= 1'b0;
          rd_sel_q <= 1'b0;
        end else begin
          wr_sel_q <= wr_sel_n;
          rd_sel_q <= rd_sel_n;
        end
      end

      for (genvar i = 0; i < NBUF; i++) begin : g_bank
        ep_rx_bank #(.CNT_W(CNT_W)) u_bank (
          .clk     (clk),
          .rst_n   (rst_n),
          .max_pkt (max_pkt),
          .wr      (rx_wr      && (wr_sel_q == 1'(i))),
          .pkt_end (rx_pkt_end && (wr_sel_q == 1'(i))),
          .rd      (rx_rd      && (rd_sel_q == 1'(i))),
          .clr     (clr_pulse  && (rd_sel_q == 1'(i))),
          .full    (bank_full[i]),
          .count   (bank_cnt[i])
        );
      end

      assign rx_avail = bank_full[rd_sel_q];
      assign rx_count = bank_cnt[rd_sel_q];

      assert_one_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pulse && $countones(rx_full) == 2) |=> ($countones(rx_full) == 1));
    end else begin : g_single
      ep_rx_bank #(.CNT_W(CNT_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .max_pkt (max_pkt),
        .wr      (rx_wr),
        .pkt_end (rx_pkt_end),
        .rd      (rx_rd),
        .clr     (clr_pulse),
        .full    (bank_full[0]),
        .count   (bank_cnt[0])
      );
      assign rx_avail = bank_full[0];
      assign rx_count = bank_cnt[0];
    end
  endgenerate

  assign rx_full = bank_full;

  assert_clear_spares_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse && !tx_wr && !tx_validate && !in_ack) |=> ($stable(tx_count) && $stable(tx_ready)));
endmodule

// File: tb/ep_buf_ctrl_tb.sv
module ep_buf_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ep_enable = 1'b0, tx_stall = 1'b0;
  logic [CW-1:0] max_pkt = '0;
  logic tx_wr = 1'b0, tx_validate = 1'b0, in_ack = 1'b0;
  logic rx_wr = 1'b0, rx_pkt_end = 1'b0, rx_rd = 1'b0, rx_clear = 1'b0;
  logic tx_ready, data_toggle, rx_avail;
  logic [CW-1:0] tx_count, rx_count;
  logic [1:0] rx_full;

  int n_chk = 0, n_bad = 0;
  logic exp_tog = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_buf_ctrl #(.CNT_W(CW), .DOUBLE_BUF(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ep_enable(ep_enable), .tx_stall(tx_stall),
    .max_pkt(max_pkt), .tx_wr(tx_wr), .tx_validate(tx_validate), .in_ack(in_ack),
    .rx_wr(rx_wr), .rx_pkt_end(rx_pkt_end), .rx_rd(rx_rd), .rx_clear(rx_clear),
    .tx_ready(tx_ready), .tx_count(tx_count), .data_toggle(data_toggle),
    .rx_full(rx_full), .rx_avail(rx_avail), .rx_count(rx_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic txw(input int n);
    for (int i = 0; i < n; i++) begin tx_wr = 1'b1; tick(); tx_wr = 1'b0; end
  endtask

  task automatic rxw(input int n);
    for (int i = 0; i < n; i++) begin rx_wr = 1'b1; tick(); rx_wr = 1'b0; end
    rx_pkt_end = 1'b1; tick(); rx_pkt_end = 1'b0;
  endtask

  task automatic rxr(input int n);
    for (int i = 0; i < n; i++) begin rx_rd = 1'b1; tick(); rx_rd = 1'b0; end
  endtask

  task automatic ack();
    in_ack = 1'b1; tick(); in_ack = 1'b0;
  endtask

  task automatic clr_cmd(input int hold);
    rx_clear = 1'b1;
    for (int i = 0; i < hold; i++) tick();
    rx_clear = 1'b0; tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("reset tx_ready", tx_ready, 0);
    chk("reset tx_count", tx_count, 0);
    chk("reset toggle", data_toggle, 0);
    chk("reset rx_full", rx_full, 0);
    chk("reset rx_count", rx_count, 0);
    rst_n = 1'b1; ep_enable = 1'b1; tick();

    // R1 / R4 / R3: auto-arm sweep over packet sizes
    for (int m = 1; m <= 8; m++) begin
      max_pkt = CW'(m);
      for (int b = 1; b <= m; b++) begin
        txw(1);
        chk("R1 count", tx_count, b);
        chk("R1 ready", tx_ready, (b == m) ? 1 : 0);
      end
      txw(2);
      chk("R4 write ignored", tx_count, m);
      ack(); exp_tog = ~exp_tog;
      chk("R3 ready clear", tx_ready, 0);
      chk("R3 count clear", tx_count, 0);
      chk("R3 toggle", data_toggle, exp_tog);
    end

    // R2: validate with every short length, including zero-length
    max_pkt = CW'(8);
    for (int k = 0; k < 8; k++) begin
      txw(k);
      chk("R2 not armed", tx_ready, 0);
      tx_validate = 1'b1; tick(); tx_validate = 1'b0;
      chk("R2 armed", tx_ready, 1);
      chk("R2 short count", tx_count, k);
      ack(); exp_tog = ~exp_tog;
      chk("R3 toggle after short", data_toggle, exp_tog);
    end

    // R3: ack when not armed does nothing
    txw(3); ack();
    chk("R3 idle ack count", tx_count, 3);
    chk("R3 idle ack toggle", data_toggle, exp_tog);

    // R9: stall blocks sending and keeps toggle
    txw(5);
    chk("R1 armed at 8", tx_ready, 1);
    tx_stall = 1'b1; ack(); tx_stall = 1'b0;
    chk("R9 stall keeps ready", tx_ready, 1);
    chk("R9 stall keeps toggle", data_toggle, exp_tog);
    ack(); exp_tog = ~exp_tog;
    chk("R3 send after stall", data_toggle, exp_tog);
    if (!exp_tog) begin ack(); txw(8); ack(); exp_tog = 1'b1; end
    chk("R9 toggle is 1", data_toggle, 1);
    ep_enable = 1'b0; tick(); ep_enable = 1'b1; exp_tog = 1'b0;
    chk("R9 disable resets toggle", data_toggle, 0);

    // R5 / R6 / R8: ping-pong over packet-length grid, third packet blocked
    max_pkt = CW'(8);
    for (int a = 1; a <= 4; a++) begin
      for (int b = 1; b <= 4; b++) begin
        rxw(a);
        chk("R5 first full", $countones(rx_full), 1);
        rxw(b);
        chk("R8 both full", $countones(rx_full), 2);
        rxw(2);
        chk("R8 oldest first", rx_count, a);
        rxr(a);
        chk("R6 one left", $countones(rx_full), 1);
        chk("R5 third packet dropped", rx_count, b);
        rxr(b - 1);
        chk("R6 partial", rx_count, 1);
        chk("R6 still avail", rx_avail, 1);
        rxr(1);
        chk("R6 emptied", $countones(rx_full), 0);
        chk("R6 avail low", rx_avail, 0);
      end
    end

    // R5: writes past max_pkt are dropped
    max_pkt = CW'(3);
    rxw(5);
    chk("R5 capped count", rx_count, 3);
    rxr(3);
    chk("R5 capped drained", rx_avail, 0);

    // R7 / R8: clears with transmit armed
    max_pkt = CW'(8);
    txw(4); tx_validate = 1'b1; tick(); tx_validate = 1'b0;
    rxw(2); rxw(5);
    clr_cmd(3);
    chk("R7 held clear one buffer", $countones(rx_full), 1);
    chk("R7 newer remains", rx_count, 5);
    chk("R7 tx ready kept", tx_ready, 1);
    chk("R7 tx count kept", tx_count, 4);
    clr_cmd(1);
    chk("R8 second clear empties", $countones(rx_full), 0);
    chk("R7 count zero", rx_count, 0);
    ack();

    // R5 / R7: zero-length receive packet needs a clear
    rxw(0);
    chk("R5 zlp full", rx_avail, 1);
    rxr(1);
    chk("R6 zlp read ignored", rx_avail, 1);
    clr_cmd(1);
    chk("R7 zlp cleared", rx_avail, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule